// File: doc/BRIEF.md
# Doubling-Period Time-Slot Scheduler

This block merges several constant-rate packet flows onto a single output link. Time on the link is divided into equal slots, and every slot belongs to at most one flow under a fixed, repeating ownership pattern. Each flow therefore leaves at its own constant period, and the spacing between its packets is the same each time. Slots are never shared between flows. The slot length is derived from the packet size, the link throughput and a guard interval. The ownership pattern comes from the flow's rank. Both are computed once when a configuration is loaded, and then stay fixed until the next load.

Flows are ranked fastest first. Ranks are taken four at a time into groups. Inside a group, the first flow repeats every second slot, the second every fourth, and the third and fourth every eighth. Each flow takes the first slot left free by the flows ranked above it. With more than four flows, the groups take turns slot by slot, so the four-flow pattern repeats once per group. Each flow owns a small queue of packet descriptors. In the first cycle of a slot, the owner's oldest descriptor is granted. If the owner's queue is empty, the slot goes unused and that flow's underrun count is incremented.

Top module: `tslot_sched`

## Requirements
- R1: The slot length in clock cycles is ceil(cfg_pkt_bytes*8 / 2^cfg_rate_log2) + cfg_guard, with a minimum of 1. It is captured on cfg_load and does not change until the next cfg_load.
- R2: Flow index f (0 = fastest) has rank position p = f mod 4 in group g = f div 4. With GROUPS = ceil(N_FLOWS/4), the grant period of the flow in slots is 2*GROUPS for p=0, 4*GROUPS for p=1 and 8*GROUPS for p=2 and p=3. grant_flow is always below N_FLOWS.
- R3: Slots are numbered from 0, and slot 0 is the cycle after cfg_load. Slot s belongs to flow 4*g+p, where g = s mod GROUPS and b = (s div GROUPS) mod 8. p is 0 when b is even, 1 when b mod 4 = 1, 2 when b = 3, and 3 when b = 7.
- R4: In the first cycle of a slot, if the owner's queue is non-empty, the oldest descriptor of that queue is granted. grant_valid is high for exactly the following cycle, with grant_flow and grant_desc.
- R5: A descriptor pushed in a slot's first cycle cannot be granted in that same slot. Every grant comes from a queue that already held data.
- R6: When a slot's owner has an empty queue, no grant is made and that flow's underrun counter (UND_W bits, wrapping) increases by exactly one. Counters otherwise stay unchanged.
- R7: A slot whose owner index is N_FLOWS or more produces no grant and changes no counter.
- R8: Each flow queue holds QDEPTH descriptors and grants them in arrival order. in_ready[f] is low exactly when queue f is full, and a push while it is low is dropped.
- R9: After reset, no grant is made until the first cfg_load. Pushes are still accepted during this time. A cfg_load restarts numbering at slot 0 and keeps queued descriptors and counters.
- R10: Reset (synchronous, active high) empties all queues, zeroes the underrun counters and clears grant_valid.
- R11: At most one grant is made per slot. Two consecutive grants under one configuration are at least one slot length apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture configuration and restart at slot 0 |
| cfg_pkt_bytes | input | BYTES_W | Packet size in bytes |
| cfg_rate_log2 | input | RATE_W | Link throughput as log2 of bits per clock |
| cfg_guard | input | GUARD_W | Guard cycles added to each slot |
| in_valid | input | N_FLOWS | Per-flow descriptor push |
| in_desc | input | N_FLOWS*DESC_W | Per-flow descriptors, flow f at bits f*DESC_W |
| in_ready | output | N_FLOWS | Per-flow queue not full |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_flow | output | FLOW_W | Granted flow index |
| grant_desc | output | DESC_W | Granted descriptor |
| underrun_cnt | output | N_FLOWS*UND_W | Per-flow empty-slot counters, flow f at bits f*UND_W |

## Verification
The assertions assume that cfg_load is a clean pulse, and that the configuration inputs are stable whenever cfg_load is high. The spacing property is reset on each load and relies on this. They also assume pushes only rely on in_ready as reported in the same cycle. The stimulus changes the configuration only through a single-cycle cfg_load with all pushes held off in that cycle. It then drives pushes at random densities, per flow or for all flows, including a push into an empty queue that lands exactly on its owner's slot start.

// File: rtl/tslot_pkg.sv
package tslot_pkg;

    // Rank position of a flow inside its group of four.
    typedef enum logic [1:0] {
        POS_FAST  = 2'd0,
        POS_HALF  = 2'd1,
        POS_QUART = 2'd2,
        POS_SHARE = 2'd3
    } pos_e;

    // Owner position for a base slot index inside an eight-slot pattern.
    function automatic pos_e pos_of_base(input logic [2:0] b);
        if (!b[0])
            return POS_FAST;
        else if (b[1:0] == 2'b01)
            return POS_HALF;
        else if (b == 3'b011)
            return POS_QUART;
        else
            return POS_SHARE;
    endfunction

    // Slot length in clock cycles: rounded-up serialisation time plus guard.
    function automatic int unsigned slot_cycles(input int unsigned nbytes,
                                                input int unsigned rlog,
                                                input int unsigned guard);
        int unsigned bits;
        int unsigned ser;
        int unsigned total;
        bits  = nbytes * 8;
        ser   = (bits + (32'd1 << rlog) - 32'd1) >> rlog;
        total = ser + guard;
        if (total == 0)
            total = 1;
        return total;
    endfunction

endpackage

// File: rtl/tslot_fifo.sv
module tslot_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push)
            mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push)
                wp <= step(wp);
            if (pop)
                rp <= step(rp);
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign dout  = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/tslot_timer.sv
module tslot_timer #(
    parameter int SLOT_W = 16,
    parameter int GROUPS = 1,
    parameter int GRP_W  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [SLOT_W-1:0] cfg_len,
    output logic [SLOT_W-1:0] len_q,
    output logic              slot_start,
    output logic [GRP_W-1:0]  grp,
    output logic [2:0]        base
);
    logic              running;
    logic [SLOT_W-1:0] cyc;
    logic              slot_end;
    logic              grp_end;

    assign slot_end = (cyc == len_q - SLOT_W'(1));
    assign grp_end  = (grp == GRP_W'(GROUPS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            len_q   <= SLOT_W'(1);
            cyc     <= '0;
            grp     <= '0;
            base    <= '0;
        end else if (cfg_load) begin
            running <= 1'b1;
            len_q   <= cfg_len;
            cyc     <= '0;
            grp     <= '0;
            base    <= '0;
        end else if (running) begin
            if (slot_end) begin
                cyc <= '0;
                if (grp_end) begin
                    grp  <= '0;
                    base <= base + 3'd1;
                end else begin
                    grp <= grp + GRP_W'(1);
                end
            end else begin
                cyc <= cyc + SLOT_W'(1);
            end
        end
    end

    assign slot_start = running && (cyc == '0) && !cfg_load;
endmodule

// File: rtl/tslot_sched.sv
module tslot_sched
    import tslot_pkg::*;
#(
    parameter int N_FLOWS = 4,
    parameter int QDEPTH  = 4,
    parameter int DESC_W  = 16,
    parameter int BYTES_W = 11,
    parameter int RATE_W  = 3,
    parameter int GUARD_W = 8,
    parameter int UND_W   = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_load,
    input  logic [BYTES_W-1:0]          cfg_pkt_bytes,
    input  logic [RATE_W-1:0]           cfg_rate_log2,
    input  logic [GUARD_W-1:0]          cfg_guard,
    input  logic [N_FLOWS-1:0]          in_valid,
    input  logic [N_FLOWS*DESC_W-1:0]   in_desc,
    output logic [N_FLOWS-1:0]          in_ready,
    output logic                        grant_valid,
    output logic [((N_FLOWS > 1) ? $clog2(N_FLOWS) : 1)-1:0] grant_flow,
    output logic [DESC_W-1:0]           grant_desc,
    output logic [N_FLOWS*UND_W-1:0]    underrun_cnt
);
    localparam int GROUPS = (N_FLOWS + 3) / 4;
    localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int OWN_W  = GRP_W + 2;
    localparam int FLOW_W = (N_FLOWS > 1) ? $clog2(N_FLOWS) : 1;
    localparam int SLOT_W = (((BYTES_W + 3) > GUARD_W) ? (BYTES_W + 3) : GUARD_W) + 1;

    typedef struct packed {
        logic              valid;
        logic [FLOW_W-1:0] flow;
        logic [DESC_W-1:0] desc;
    } grant_t;

    logic [SLOT_W-1:0] cfg_len;
    logic [SLOT_W-1:0] cur_len;
    logic              slot_start;
    logic [GRP_W-1:0]  grp;
    logic [2:0]        base;
    pos_e              pos;
    logic [1:0]        pos_bits;
    logic [OWN_W-1:0]  owner;

    logic [N_FLOWS-1:0] sel, pop, miss, push_v, empty_v, full_v, q_nonempty;
    logic [DESC_W-1:0]  heads [N_FLOWS];

    grant_t nxt, cur;

    assign cfg_len = SLOT_W'(slot_cycles(32'(cfg_pkt_bytes), 32'(cfg_rate_log2), 32'(cfg_guard)));

    tslot_timer #(
        .SLOT_W(SLOT_W),
        .GROUPS(GROUPS),
        .GRP_W (GRP_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .cfg_load  (cfg_load),
        .cfg_len   (cfg_len),
        .len_q     (cur_len),
        .slot_start(slot_start),
        .grp       (grp),
        .base      (base)
    );

    assign pos      = pos_of_base(base);
    assign pos_bits = pos;
    assign owner    = {grp, pos_bits};

    for (genvar f = 0; f < N_FLOWS; f++) begin : g_flow
        logic [UND_W-1:0] und_q;

        assign sel[f]        = slot_start && (owner == OWN_W'(f));
        assign pop[f]        = sel[f] && !empty_v[f];
        assign miss[f]       = sel[f] && empty_v[f];
        assign push_v[f]     = in_valid[f] && !full_v[f];
        assign in_ready[f]   = !full_v[f];
        assign q_nonempty[f] = !empty_v[f];

        tslot_fifo #(
            .DEPTH(QDEPTH),
            .W    (DESC_W)
        ) u_q (
            .clk  (clk),
            .rst  (rst),
            .push (push_v[f]),
            .din  (in_desc[f*DESC_W +: DESC_W]),
            .pop  (pop[f]),
            .dout (heads[f]),
            .empty(empty_v[f]),
            .full (full_v[f])
        );

        always_ff @(posedge clk) begin
            if (rst)
                und_q <= '0;
            else if (miss[f])
                und_q <= und_q + UND_W'(1);
        end

        assign underrun_cnt[f*UND_W +: UND_W] = und_q;
    end

    always_comb begin
        nxt       = '0;
        nxt.valid = |pop;
        nxt.flow  = owner[FLOW_W-1:0];
        for (int i = 0; i < N_FLOWS; i++) begin
            if (pop[i])
                nxt.desc = nxt.desc | heads[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else
            cur <= nxt;
    end

    assign grant_valid = cur.valid;
    assign grant_flow  = cur.flow;
    assign grant_desc  = cur.desc;
endmodule

// File: rtl/tslot_sched_chk.sv
module tslot_sched_chk #(
    parameter int N_FLOWS = 4,
    parameter int FLOW_W  = 2,
    parameter int UND_W   = 8,
    parameter int SLOT_W  = 15
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cfg_load,
    input logic                     grant_valid,
    input logic [FLOW_W-1:0]        grant_flow,
    input logic [N_FLOWS*UND_W-1:0] underrun_cnt,
    input logic [N_FLOWS-1:0]       q_nonempty,
    input logic [SLOT_W-1:0]        cur_len
);
    logic            cfg_seen;
    logic            seen_grant;
    logic [SLOT_W:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_seen   <= 1'b0;
            seen_grant <= 1'b0;
            gap        <= '0;
        end else begin
            if (cfg_load)
                cfg_seen <= 1'b1;
            if (cfg_load)
                seen_grant <= 1'b0;
            else if (grant_valid)
                seen_grant <= 1'b1;
            if (grant_valid)
                gap <= (SLOT_W+1)'(1);
            else if (gap != '1)
                gap <= gap + (SLOT_W+1)'(1);
        end
    end

    p_slot_spacing_r11: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && seen_grant && !cfg_load) |-> (gap >= {1'b0, cur_len}));

    p_flow_range_r2: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (int'(grant_flow) < N_FLOWS));

    p_idle_unconfigured_r9: assert property (@(posedge clk) disable iff (rst)
        !cfg_seen |-> !grant_valid);

    p_grant_has_data_r5: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> |($past(q_nonempty) & (N_FLOWS'(1) << grant_flow)));

    for (genvar f = 0; f < N_FLOWS; f++) begin : g_und
        p_underrun_step_r6: assert property (@(posedge clk) disable iff (rst)
            (underrun_cnt[f*UND_W +: UND_W] == $past(underrun_cnt[f*UND_W +: UND_W])) ||
            (underrun_cnt[f*UND_W +: UND_W] == UND_W'($past(underrun_cnt[f*UND_W +: UND_W]) + 1'b1)));
    end
endmodule

bind tslot_sched tslot_sched_chk #(
    .N_FLOWS(N_FLOWS),
    .FLOW_W (FLOW_W),
    .UND_W  (UND_W),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_load    (cfg_load),
    .grant_valid (grant_valid),
    .grant_flow  (grant_flow),
    .underrun_cnt(underrun_cnt),
    .q_nonempty  (q_nonempty),
    .cur_len     (cur_len)
);

// File: tb/sim_tslot_sched.sv
module sim_tslot_sched;
    localparam int N  = 6;
    localparam int QD = 4;
    localparam int DW = 16;
    localparam int BW = 11;
    localparam int RW = 3;
    localparam int GW = 8;
    localparam int UW = 8;
    localparam int G  = (N + 3) / 4;
    localparam int FW = $clog2(N);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst = 1'b1;
    logic            cfg_load = 1'b0;
    logic [BW-1:0]   cfg_pkt_bytes = '0;
    logic [RW-1:0]   cfg_rate_log2 = '0;
    logic [GW-1:0]   cfg_guard = '0;
    logic [N-1:0]    in_valid = '0;
    logic [N*DW-1:0] in_desc = '0;
    logic [N-1:0]    in_ready;
    logic            grant_valid;
    logic [FW-1:0]   grant_flow;
    logic [DW-1:0]   grant_desc;
    logic [N*UW-1:0] underrun_cnt;

    tslot_sched #(
        .N_FLOWS(N), .QDEPTH(QD), .DESC_W(DW), .BYTES_W(BW),
        .RATE_W(RW), .GUARD_W(GW), .UND_W(UW)
    ) u0 (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_pkt_bytes(cfg_pkt_bytes),
        .cfg_rate_log2(cfg_rate_log2), .cfg_guard(cfg_guard), .in_valid(in_valid),
        .in_desc(in_desc), .in_ready(in_ready), .grant_valid(grant_valid),
        .grant_flow(grant_flow), .grant_desc(grant_desc), .underrun_cnt(underrun_cnt)
    );

    int checks = 0;
    int errors = 0;
    int desc_ctr = 1;
    bit mon_on = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Requirement-level helpers.
    function automatic int owner_of(input int s);
        int g, b, p;
        g = s % G;
        b = (s / G) % 8;
        if (b % 2 == 0)      p = 0;
        else if (b % 4 == 1) p = 1;
        else if (b == 3)     p = 2;
        else                 p = 3;
        return g * 4 + p;
    endfunction

    function automatic int period_of(input int f);
        int p;
        p = f % 4;
        return ((p == 0) ? 2 : (p == 1) ? 4 : 8) * G;
    endfunction

    function automatic int exp_len(input int nb, input int rl, input int gd);
        int q, t;
        q = (nb * 8 + (1 << rl) - 1) / (1 << rl);
        t = q + gd;
        return (t == 0) ? 1 : t;
    endfunction

    // Behavioural reference model.
    bit          m_run = 1'b0;
    int          m_len = 1;
    int          m_cyc = 0;
    int          m_s = 0;
    int          m_t = 0;
    int unsigned mq [N][$];
    int          m_und [N];
    bit          rdy_pre [N];
    bit          e_gv = 1'b0;
    int          e_gf = 0;
    int          e_gd = 0;
    int          last_slot [N];
    bit          have_last [N];
    int          last_any_t = 0;
    bit          have_any = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_run = 1'b0; m_cyc = 0; m_s = 0; m_t = 0; e_gv = 1'b0; have_any = 1'b0;
            for (int i = 0; i < N; i++) begin
                mq[i].delete();
                m_und[i] = 0;
                have_last[i] = 1'b0;
            end
        end else begin
            for (int i = 0; i < N; i++) rdy_pre[i] = (mq[i].size() < QD);
            e_gv = 1'b0;
            if (cfg_load) begin
                m_run = 1'b1;
                m_len = exp_len(int'(cfg_pkt_bytes), int'(cfg_rate_log2), int'(cfg_guard));
                m_cyc = 0; m_s = 0; m_t = 0; have_any = 1'b0;
                for (int i = 0; i < N; i++) have_last[i] = 1'b0;
            end else if (m_run) begin
                m_t++;
                if (m_cyc == 0) begin
                    int o;
                    o = owner_of(m_s);
                    if (o < N) begin
                        if (mq[o].size() > 0) begin
                            e_gv = 1'b1;
                            e_gf = o;
                            e_gd = int'(mq[o].pop_front());
                        end else begin
                            m_und[o]++;
                        end
                    end
                end
                m_cyc++;
                if (m_cyc == m_len) begin
                    m_cyc = 0;
                    m_s++;
                end
            end
            for (int i = 0; i < N; i++)
                if (in_valid[i] && rdy_pre[i]) mq[i].push_back(int'(in_desc[i*DW +: DW]));
        end
    end

    always @(negedge clk) begin
        if (!rst && mon_on) begin
            chk(grant_valid == e_gv, m_run ? "R4" : "R9", "grant_valid", grant_valid, e_gv);
            if (e_gv && grant_valid) begin
                chk(int'(grant_flow) == e_gf, "R4", "grant_flow", grant_flow, e_gf);
                chk(int'(grant_desc) == e_gd, "R8", "grant_desc order", grant_desc, e_gd);
            end
            for (int i = 0; i < N; i++) begin
                chk(int'(underrun_cnt[i*UW +: UW]) == (m_und[i] % (1 << UW)), "R6",
                    $sformatf("underrun flow %0d", i), underrun_cnt[i*UW +: UW], m_und[i] % (1 << UW));
                chk(in_ready[i] == (mq[i].size() < QD), "R8",
                    $sformatf("in_ready flow %0d", i), in_ready[i], mq[i].size() < QD);
            end
            if (m_run && m_t >= 1 && grant_valid) begin
                int s, f;
                chk(((m_t - 1) % m_len) == 0, "R1", "grant off slot boundary", (m_t - 1) % m_len, 0);
                s = (m_t - 1) / m_len;
                f = int'(grant_flow);
                chk(owner_of(s) == f, "R3", "slot owner", f, owner_of(s));
                if (f < N) begin
                    if (have_last[f])
                        chk(((s - last_slot[f]) % period_of(f)) == 0, "R2", "period",
                            s - last_slot[f], period_of(f));
                    last_slot[f] = s;
                    have_last[f] = 1'b1;
                end
                if (have_any)
                    chk((m_t - last_any_t) >= m_len, "R11", "grant spacing", m_t - last_any_t, m_len);
                last_any_t = m_t;
                have_any = 1'b1;
            end
            if (m_run && m_t >= 1 && ((m_t - 1) % m_len) == 0 && owner_of((m_t - 1) / m_len) >= N)
                chk(!grant_valid, "R7", "grant in unowned slot", grant_valid, 0);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = '0; cfg_load = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_cfg(input int nb, input int rl, input int gd);
        @(negedge clk);
        in_valid      = '0;
        cfg_pkt_bytes = BW'(nb);
        cfg_rate_log2 = RW'(rl);
        cfg_guard     = GW'(gd);
        cfg_load      = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic drive(input int n, input int pct, input logic [N-1:0] mask);
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < N; i++) begin
                in_valid[i] = mask[i] && (($urandom % 100) < pct);
                in_desc[i*DW +: DW] = DW'(desc_ctr);
                desc_ctr++;
            end
            @(negedge clk);
        end
        in_valid = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R10: reset state at the ports.
        chk(grant_valid == 1'b0, "R10", "grant_valid after reset", grant_valid, 0);
        chk(in_ready == '1, "R10", "in_ready after reset", in_ready, '1);
        chk(underrun_cnt == '0, "R10", "underrun after reset", underrun_cnt, 0);
        mon_on = 1'b1;

        // R5: push into an empty queue on its owner's slot start; L = 5.
        do_cfg(8, 4, 1);
        in_valid[0] = 1'b1;
        in_desc[0 +: DW] = DW'(16'hA5A5);
        @(negedge clk);
        in_valid = '0;
        chk(grant_valid == 1'b0, "R5", "grant on arrival slot", grant_valid, 0);
        chk(int'(underrun_cnt[0 +: UW]) == 1, "R5", "underrun on arrival slot", underrun_cnt[0 +: UW], 1);
        drive(600, 50, '1);

        // R9: fresh reset, pushes accepted, no grants before configuration.
        do_reset();
        drive(40, 60, '1);

        // Saturated traffic with a short slot (L = 2).
        do_cfg(3, 4, 0);
        drive(400, 100, '1);
        // Sparse traffic with the minimum slot (L = 1).
        do_cfg(0, 0, 0);
        drive(300, 20, '1);
        // Two flows only, ceiling rounding plus guard (L = 8).
        do_cfg(3, 2, 2);
        drive(600, 70, 6'b100001);
        drive(100, 0, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule